// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two 18-bit ports, side A and side B. It has two independent paths, A-to-B and B-to-A. Each path has one storage element per bit and three controls: a latch enable, a strobe, and an output enable. The latch enable selects the mode. While it is high, the path is transparent and the far side follows the near side in the same cycle. While it is low, the stored word drives the far side. That word changes only when the path's strobe rises.

The block is synchronous to one system clock. Each strobe is sampled on that clock, and a rise is recognised when one sample is high and the sample before it was low. A captured word appears on the output one system clock after the sample that saw the rise. The output enables have opposite polarity: the A-to-B enable is active high and the B-to-A enable is active low.

Each side is modelled as three separate vectors: an input, an output and a per-bit drive enable. A drive enable of zero stands for high impedance. A top level pairs these vectors with its own tri-state pads.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: Each path carries WIDTH bits, with a default of 18, and bit i of the input maps to bit i of the far-side output.
- R2: While a path's latch enable is 1, its output equals its input in the same cycle and follows every change of that input.
- R3: While a path's latch enable is 0 and its strobe stays at a constant level (high or low), the output keeps its value whatever the input does.
- R4: While a path's latch enable is 0, a 0-to-1 change of its strobe, as sampled by the system clock, stores the input present at that sample. The stored word appears on the output after that clock edge.
- R5: The A-to-B output enable is active high. When it is 1, all bits of `b_oe` are 1. When it is 0, all bits of `b_oe` are 0 (side B is high impedance).
- R6: The B-to-A output enable is active low. When `ba_oe_n` is 0, all bits of `a_oe` are 1. When it is 1, all bits of `a_oe` are 0.
- R7: When the latch enable falls, with the strobe either high or low, the output holds the input value from the last cycle in which the latch enable was 1.
- R8: A strobe rise while the latch enable is 1 has no effect of its own: the output keeps following the input, and the word seen after the latch enable falls is the input from the last cycle in which the latch enable was 1.
- R9: A synchronous active-low reset clears both stored words to zero. A strobe that is already high when reset is released does not count as a rise.
- R10: Activity on the controls or data of one path leaves the output and drive enables of the other path unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Data received from side A |
| a_out | output | WIDTH | Data driven onto side A |
| a_oe | output | WIDTH | Per-bit drive enable for side A |
| b_in | input | WIDTH | Data received from side B |
| b_out | output | WIDTH | Data driven onto side B |
| b_oe | output | WIDTH | Per-bit drive enable for side B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B capture strobe, rising edge stores |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A capture strobe, rising edge stores |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The hardest case to reach from the ports is the hand-over between modes. This covers a latch enable that falls while the strobe is already high, and a strobe that rises one cycle after the latch enable falls. Both cases depend on which input the storage element saw in its last transparent cycle. The bench steps the latch enable and the strobe one cycle at a time, and it changes the input at the same moment each control moves. A wrong choice between the old and new word then shows on the held output. The same sequences run for both paths, each with its own enable polarity. Meanwhile the idle path is checked for stillness.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_PASS    = 2'd0,
        MODE_HOLD    = 2'd1,
        MODE_CAPTURE = 2'd2
    } xcvr_mode_e;

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl;
        if (!rst_n) begin
            s_d.prev = 1'b1;   // a level held high across reset is not an edge
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign rise = lvl & ~s_q.prev;

    // R9: no edge is reported in the first cycle after reset
    a_r9_no_edge_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !rise);

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import bidir_xcvr_pkg::*;
#(
    parameter int WIDTH   = 18,
    parameter bit EN_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             le,
    input  logic             stb,
    input  logic             en,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] doe
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [MSB:0] word;
    } path_st_t;

    path_st_t   s_d, s_q;
    xcvr_mode_e mode;
    logic       stb_rise;
    logic       drive_on;

    xcvr_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (stb),
        .rise  (stb_rise)
    );

    always_comb begin
        if (le) begin
            mode = MODE_PASS;
        end else if (stb_rise) begin
            mode = MODE_CAPTURE;
        end else begin
            mode = MODE_HOLD;
        end

        s_d = s_q;
        case (mode)
            MODE_PASS:    s_d.word = din;
            MODE_CAPTURE: s_d.word = din;
            default:      s_d.word = s_q.word;
        endcase
        if (!rst_n) begin
            s_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign dout = (mode == MODE_PASS) ? din : s_q.word;

    generate
        if (EN_HIGH) begin : g_en_high
            assign drive_on = en;
        end else begin : g_en_low
            assign drive_on = ~en;
        end
    endgenerate

    assign doe = {WIDTH{drive_on}};

    // R3: latched, no strobe rise in the previous cycle -> output steady
    a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && $past(!le) && $past(!stb_rise)) |-> $stable(dout));

    // R4: strobe rise while latched stores the sampled input
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && stb_rise) |=> (s_q.word == $past(din)));

    // R7: closing the latch keeps the last transparent input
    a_r7_close_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(le) |-> (dout == $past(din)));

    // R9: storage is zero right after reset
    a_r9_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (s_q.word == '0));

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             ab_le,
    input  logic             ab_stb,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_stb,
    input  logic             ba_oe_n
);

    xcvr_path #(.WIDTH(WIDTH), .EN_HIGH(1'b1)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (a_in),
        .le    (ab_le),
        .stb   (ab_stb),
        .en    (ab_oe),
        .dout  (b_out),
        .doe   (b_oe)
    );

    xcvr_path #(.WIDTH(WIDTH), .EN_HIGH(1'b0)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (b_in),
        .le    (ba_le),
        .stb   (ba_stb),
        .en    (ba_oe_n),
        .dout  (a_out),
        .doe   (a_oe)
    );

    // R5: A-to-B enable low floats side B
    a_r5_b_float: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe |-> (b_oe == '0));

    // R6: B-to-A enable is active low
    a_r6_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_n |-> (a_oe == '1));

    // R2: transparent paths pass input through
    a_r2_ab_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in));

    // R10: a latched, quiet B-to-A path ignores A-to-B activity
    a_r10_ba_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && $past(!ba_le) && $stable(ba_stb) && $past(!ba_stb)) |-> $stable(a_out));

endmodule

// File: tb/bidir_reg_xcvr_test.sv
module bidir_reg_xcvr_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ab_le = 1'b0, ab_stb = 1'b0, ab_oe = 1'b1;
    logic         ba_le = 1'b0, ba_stb = 1'b0, ba_oe_n = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    bidir_reg_xcvr #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_le(ab_le), .ab_stb(ab_stb), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_stb(ba_stb), .ba_oe_n(ba_oe_n)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_le(int d, logic v);
        if (d == 0) ab_le = v; else ba_le = v;
    endtask
    task automatic set_stb(int d, logic v);
        if (d == 0) ab_stb = v; else ba_stb = v;
    endtask
    task automatic set_in(int d, logic [W-1:0] v);
        if (d == 0) a_in = v; else b_in = v;
    endtask
    task automatic set_en(int d, logic on);
        if (d == 0) ab_oe = on; else ba_oe_n = ~on;
    endtask
    function automatic logic [W-1:0] out_of(int d);
        return (d == 0) ? b_out : a_out;
    endfunction
    function automatic logic [W-1:0] oe_of(int d);
        return (d == 0) ? b_oe : a_oe;
    endfunction
    function automatic logic [W-1:0] other_out(int d);
        return (d == 0) ? a_out : b_out;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        ab_stb = 1'b1;            // strobe high across reset release
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R9 b_out cleared", b_out, '0);
        chk("R9 a_out cleared", a_out, '0);
        a_in = 18'h3FFFF;
        step();
        chk("R9 held strobe is no edge", b_out, '0);
        ab_stb = 1'b0;
        a_in = '0;
        step();
    endtask

    task automatic t_transparent(int d);
        set_le(d, 1'b1);
        set_in(d, 18'h15A3C ^ d);
        #1 chk("R2 pass", out_of(d), 18'h15A3C ^ d);
        set_in(d, 18'h0F0F1);
        #1 chk("R2 follows same cycle", out_of(d), 18'h0F0F1);
        step();
        set_in(d, 18'h20001);   // R1: top and bottom bits map through
        #1 chk("R1 bit mapping", out_of(d), 18'h20001);
        step();
    endtask

    task automatic t_close_and_hold(int d, logic stb_lvl);
        logic [W-1:0] held;
        held = 18'h2B6D1 ^ {17'd0, stb_lvl};
        set_stb(d, stb_lvl);
        set_le(d, 1'b1);
        set_in(d, held);
        step();
        set_le(d, 1'b0);
        set_in(d, 18'h1111F);
        #1 chk("R7 close keeps last transparent", out_of(d), held);
        step();
        set_in(d, 18'h3C3C3);
        step();
        step();
        chk("R3 hold with steady strobe", out_of(d), held);
        set_stb(d, 1'b0);
        step();
    endtask

    task automatic t_capture(int d);
        logic [W-1:0] other;
        other = other_out(d);
        set_le(d, 1'b0);
        set_stb(d, 1'b0);
        step();
        set_in(d, 18'h0ACE5);
        set_stb(d, 1'b1);
        step();
        chk("R4 rising strobe stores", out_of(d), 18'h0ACE5);
        set_in(d, 18'h2F00D);
        step();
        chk("R3 no second capture", out_of(d), 18'h0ACE5);
        set_stb(d, 1'b0);
        step();
        chk("R3 falling strobe ignored", out_of(d), 18'h0ACE5);
        chk("R10 other path untouched", other_out(d), other);
    endtask

    task automatic t_edge_while_open(int d);
        set_le(d, 1'b1);
        set_stb(d, 1'b0);
        set_in(d, 18'h01234);
        step();
        set_stb(d, 1'b1);
        set_in(d, 18'h05678);
        step();
        chk("R8 edge while open still passes", out_of(d), 18'h05678);
        set_in(d, 18'h09ABC);
        step();
        set_le(d, 1'b0);
        set_in(d, 18'h3FFFF);
        step();
        chk("R8 held word is last transparent", out_of(d), 18'h09ABC);
        set_stb(d, 1'b0);
        step();
    endtask

    task automatic t_edge_after_close(int d);
        set_stb(d, 1'b0);
        set_le(d, 1'b1);
        set_in(d, 18'h11223);
        step();
        set_le(d, 1'b0);
        step();
        set_in(d, 18'h24681);
        set_stb(d, 1'b1);
        step();
        chk("R4 edge just after close captures", out_of(d), 18'h24681);
        set_stb(d, 1'b0);
        step();
    endtask

    task automatic t_enable(int d);
        set_en(d, 1'b0);
        #1 chk(d == 0 ? "R5 disabled floats" : "R6 disabled floats", oe_of(d), '0);
        set_en(d, 1'b1);
        #1 chk(d == 0 ? "R5 enabled drives" : "R6 enabled drives", oe_of(d), '1);
        chk("R10 other enable untouched", (d == 0) ? a_oe : b_oe, '1);
        step();
    endtask

    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        for (int d = 0; d < 2; d++) begin
            t_transparent(d);
            set_le(d, 1'b0);
            step();
            t_close_and_hold(d, 1'b1);
            t_close_and_hold(d, 1'b0);
            t_capture(d);
            t_edge_while_open(d);
            t_edge_after_close(d);
            t_enable(d);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule